// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets a host drive a serial configuration flash through a set of byte-wide registers. Before each transfer the host loads a 16-bit clock count, a command byte, up to three address bytes and any outgoing data bytes. It then writes a start key. The engine lowers chip select and toggles the serial clock exactly the programmed number of times. It shifts command, address and data out on the serial output and stores every bit sampled on the serial input in a capture buffer. While the transfer is running, a busy byte reads nonzero.

All register bytes sit on an 8-byte grid. Bits leave and enter least-significant first, so the host supplies address bytes already bit-reversed and uses bit-reversed command codes. For example, 0xA0 is a status read of 16 clocks and 0xD5 is an identifier read of 40 clocks. A status read leaves the status byte at offset 0x20, where bit 7 reports that the flash is still busy erasing or writing. An identifier read leaves the identifier at offset 0x38. Array reads and page writes add 8 clocks per data byte, and a page write carries up to 128 bytes.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the serial output is low and offset 0x01 reads 0x00.
- R2: Chip select falls on the start edge and stays low for one serial period (2*SCK_HALF system cycles) before the first rising clock edge. Each clock half lasts SCK_HALF cycles. Chip select rises one full period after the last falling edge.
- R3: The serial output carries the command byte (written at 0x10), then the address bytes written at 0x18, 0x20 and 0x28 in that order, then outgoing data byte i (written at 0x30+8*i). Each byte goes out least-significant bit first. A bit changes only while the clock is low, and the first bit is present from the moment chip select falls.
- R4: A transfer has exactly N rising clock edges, where N is the 16-bit value {byte at 0x00, byte at 0x08}. With N = 0, chip select frames two periods with no clock edge.
- R5: A read has one cycle of latency. Offset 0x01 reads 0x01 while a transfer runs and 0x00 otherwise.
- R6: The input line is sampled at each rising edge. Sample k becomes bit k%8 of capture byte k/8. Capture byte 1, which is the status byte, reads at offset 0x20.
- R7: Capture byte 4+i reads at offset 0x38+8*i for i below RX_BYTES. Offsets in that window at or beyond RX_BYTES read 0x00. Only complete bytes are stored.
- R8: A transfer starts only when 0xFF is written to offset 0x7F8 while idle. Other values at that offset, and any start write during a transfer, have no effect.
- R9: Register and data-byte writes made during a transfer are dropped. They neither alter the running transfer nor carry into the next one.
- R10: Clocks that reach beyond the last data byte (index TX_BYTES or higher) shift out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one register byte |
| bus_addr | input | ADDR_W | Byte offset for the write or read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the address |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with SCK_HALF = 1, TX_BYTES = 8 and RX_BYTES = 6. The two-cycle serial period is the tightest case for the data-byte prefetch, because each clock half lasts a single cycle. The small buffers let short transfers run past the last outgoing data byte, where zeros are expected. They also let reads cross the end of the capture window, including a trailing partial byte. A 260-clock page write uses the high count byte. During that write, the bench issues a second start and overwrites registers, which tests that the running transfer is left alone.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_HIGH, PH_LOW, PH_TRAIL} sfe_phase_e;

  // register slots: byte offset divided by the 8-byte grid
  localparam int unsigned SLOT_CNT_HI  = 0;
  localparam int unsigned SLOT_CNT_LO  = 1;
  localparam int unsigned SLOT_CMD     = 2;
  localparam int unsigned SLOT_ADR_HI  = 3;
  localparam int unsigned SLOT_ADR_MID = 4;
  localparam int unsigned SLOT_ADR_LO  = 5;
  localparam int unsigned SLOT_TX0     = 6;
  localparam int unsigned SLOT_RX0     = 7;
  localparam int unsigned SLOT_STATUS  = 4;
  localparam int unsigned SLOT_GO      = 255;
  localparam int unsigned BUSY_OFFSET  = 1;
  localparam logic [7:0]  GO_KEY       = 8'hFF;
  localparam int unsigned HDR_BYTES    = 4;
  localparam int unsigned STATUS_BYTE  = 1;
endpackage

// File: rtl/sfe_regs.sv
module sfe_regs
  import sfe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned TX_BYTES = 128,
  localparam int unsigned TXA_W   = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              busy,
  output logic              go,
  output logic [15:0]       nclk,
  output logic [7:0]        cmd,
  output logic [7:0]        adr_hi,
  output logic [7:0]        adr_mid,
  output logic [7:0]        adr_lo,
  input  logic [TXA_W-1:0]  tx_raddr,
  output logic [7:0]        tx_rdata
);
  localparam int unsigned SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] tx_off;
  logic              wr_ok;
  logic              tx_hit;
  logic [7:0]        tx_mem [TX_BYTES];

  assign slot   = bus_addr[ADDR_W-1:3];
  assign wr_ok  = bus_wr && (bus_addr[2:0] == 3'd0) && !busy;
  assign tx_off = slot - SLOT_W'(SLOT_TX0);
  assign tx_hit = wr_ok && (32'(slot) >= SLOT_TX0) && (32'(tx_off) < TX_BYTES);
  assign go     = wr_ok && (32'(slot) == SLOT_GO) && (bus_wdata == GO_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      nclk    <= '0;
      cmd     <= '0;
      adr_hi  <= '0;
      adr_mid <= '0;
      adr_lo  <= '0;
    end else if (wr_ok) begin
      case (32'(slot))
        SLOT_CNT_HI:  nclk[15:8] <= bus_wdata;
        SLOT_CNT_LO:  nclk[7:0]  <= bus_wdata;
        SLOT_CMD:     cmd        <= bus_wdata;
        SLOT_ADR_HI:  adr_hi     <= bus_wdata;
        SLOT_ADR_MID: adr_mid    <= bus_wdata;
        SLOT_ADR_LO:  adr_lo     <= bus_wdata;
        default: ;
      endcase
    end
  end

  // single write port, registered read port
  always_ff @(posedge clk) begin
    if (tx_hit) tx_mem[tx_off[TXA_W-1:0]] <= bus_wdata;
    tx_rdata <= tx_mem[tx_raddr];
  end

  // R9
  hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(nclk) && $stable(cmd) && $stable(adr_hi) && $stable(adr_mid) && $stable(adr_lo)));
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned TX_BYTES = 128,
  localparam int unsigned TXA_W   = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [15:0]      nclk,
  input  logic [7:0]       cmd,
  input  logic [7:0]       adr_hi,
  input  logic [7:0]       adr_mid,
  input  logic [7:0]       adr_lo,
  input  logic [7:0]       tx_rdata,
  output logic [TXA_W-1:0] tx_raddr,
  output logic             busy,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             smp,
  output logic [15:0]      smp_idx
);
  localparam int unsigned PER   = 2 * SCK_HALF;
  localparam int unsigned CNT_W = $clog2(PER + 1);

  sfe_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      bit_cnt;
  logic [15:0]      nb;
  logic [12:0]      nb_byte;
  logic [12:0]      tx_idx;
  logic [7:0]       next_byte;
  logic             next_bit;
  logic             per_end;
  logic             half_end;

  assign per_end  = (cnt == CNT_W'(PER - 1));
  assign half_end = (cnt == CNT_W'(SCK_HALF - 1));

  // the byte for the next bit is fetched a whole bit ahead of its use
  assign nb       = bit_cnt + 16'd1;
  assign nb_byte  = nb[15:3];
  assign tx_idx   = nb_byte - 13'(HDR_BYTES);
  assign tx_raddr = tx_idx[TXA_W-1:0];

  always_comb begin
    case (nb_byte)
      13'd0:   next_byte = cmd;
      13'd1:   next_byte = adr_hi;
      13'd2:   next_byte = adr_mid;
      13'd3:   next_byte = adr_lo;
      default: next_byte = (32'(tx_idx) < TX_BYTES) ? tx_rdata : 8'h00;
    endcase
    next_bit = next_byte[nb[2:0]];
  end

  assign smp     = ((phase == PH_LEAD) && per_end && (nclk != 16'd0)) ||
                   ((phase == PH_LOW) && half_end);
  assign smp_idx = (phase == PH_LEAD) ? 16'd0 : bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      bit_cnt  <= '0;
      busy     <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      spi_mosi <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (go) begin
            phase    <= PH_LEAD;
            cnt      <= '0;
            bit_cnt  <= '0;
            busy     <= 1'b1;
            spi_cs_n <= 1'b0;
            spi_mosi <= cmd[0];
          end
        end
        PH_LEAD: begin
          if (per_end) begin
            cnt <= '0;
            if (nclk == 16'd0) begin
              phase    <= PH_TRAIL;
              spi_mosi <= 1'b0;
            end else begin
              phase   <= PH_HIGH;
              spi_sck <= 1'b1;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (half_end) begin
            cnt     <= '0;
            spi_sck <= 1'b0;
            if (bit_cnt == nclk - 16'd1) begin
              phase    <= PH_TRAIL;
              spi_mosi <= 1'b0;
            end else begin
              phase    <= PH_LOW;
              bit_cnt  <= nb;
              spi_mosi <= next_bit;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_LOW: begin
          if (half_end) begin
            cnt     <= '0;
            phase   <= PH_HIGH;
            spi_sck <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_TRAIL: begin
          if (per_end) begin
            cnt      <= '0;
            phase    <= PH_IDLE;
            busy     <= 1'b0;
            spi_cs_n <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  sck_framed_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n);
  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> ($past(phase) == PH_TRAIL && !spi_sck));
  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH || phase == PH_LOW) |-> (bit_cnt < nclk));
  // R8
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> (phase == PH_IDLE && !busy));
endmodule

// File: rtl/sfe_capture.sv
module sfe_capture
  import sfe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned RX_BYTES = 247
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp,
  input  logic [15:0]       smp_idx,
  input  logic              spi_miso,
  input  logic              busy,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_rdata
);
  localparam int unsigned CAP_BYTES = RX_BYTES + HDR_BYTES;
  localparam int unsigned CAPA_W    = $clog2(CAP_BYTES);
  localparam int unsigned SLOT_W    = ADDR_W - 3;

  logic [7:0]        cap_mem [CAP_BYTES];
  logic [7:0]        sh;
  logic [7:0]        byte_in;
  logic              store;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] rx_off;
  logic              aligned;
  logic              rx_hit;
  logic              st_hit;
  logic [CAPA_W-1:0] raddr;
  logic [7:0]        rd_q;
  logic              mem_sel_q;
  logic              busy_sel_q;
  logic [15:0]       last_idx_q;

  assign byte_in = {spi_miso, sh[7:1]};
  assign store   = smp && (smp_idx[2:0] == 3'd7) && (32'(smp_idx[15:3]) < CAP_BYTES);

  always_ff @(posedge clk) begin
    if (smp) sh <= byte_in;
    if (store) cap_mem[smp_idx[CAPA_W+2:3]] <= byte_in;
    rd_q <= cap_mem[raddr];
  end

  assign slot    = bus_addr[ADDR_W-1:3];
  assign aligned = (bus_addr[2:0] == 3'd0);
  assign rx_off  = slot - SLOT_W'(SLOT_RX0);
  assign rx_hit  = aligned && (32'(slot) >= SLOT_RX0) && (32'(rx_off) < RX_BYTES);
  assign st_hit  = aligned && (32'(slot) == SLOT_STATUS);
  assign raddr   = st_hit ? CAPA_W'(STATUS_BYTE) : CAPA_W'(32'(rx_off) + HDR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_sel_q  <= 1'b0;
      busy_sel_q <= 1'b0;
      last_idx_q <= '0;
    end else begin
      mem_sel_q  <= rx_hit || st_hit;
      busy_sel_q <= (32'(bus_addr) == BUSY_OFFSET);
      if (smp) last_idx_q <= smp_idx;
    end
  end

  assign bus_rdata = busy_sel_q ? {7'd0, busy} : (mem_sel_q ? rd_q : 8'h00);

  // R6
  sample_order_chk: assert property (@(posedge clk) disable iff (rst)
    (smp && smp_idx != 16'd0) |-> (smp_idx == last_idx_q + 16'd1));
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned TX_BYTES = 128,
  parameter int unsigned RX_BYTES = 247
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned TXA_W = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1;

  logic             go;
  logic             busy;
  logic [15:0]      nclk;
  logic [7:0]       cmd;
  logic [7:0]       adr_hi;
  logic [7:0]       adr_mid;
  logic [7:0]       adr_lo;
  logic [TXA_W-1:0] tx_raddr;
  logic [7:0]       tx_rdata;
  logic             smp;
  logic [15:0]      smp_idx;

  sfe_regs #(.ADDR_W(ADDR_W), .TX_BYTES(TX_BYTES)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .go(go), .nclk(nclk), .cmd(cmd), .adr_hi(adr_hi), .adr_mid(adr_mid),
    .adr_lo(adr_lo), .tx_raddr(tx_raddr), .tx_rdata(tx_rdata)
  );

  sfe_seq #(.SCK_HALF(SCK_HALF), .TX_BYTES(TX_BYTES)) u_seq (
    .clk(clk), .rst(rst), .go(go), .nclk(nclk), .cmd(cmd), .adr_hi(adr_hi),
    .adr_mid(adr_mid), .adr_lo(adr_lo), .tx_rdata(tx_rdata), .tx_raddr(tx_raddr),
    .busy(busy), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .smp(smp), .smp_idx(smp_idx)
  );

  sfe_capture #(.ADDR_W(ADDR_W), .RX_BYTES(RX_BYTES)) u_capture (
    .clk(clk), .rst(rst), .smp(smp), .smp_idx(smp_idx), .spi_miso(spi_miso),
    .busy(busy), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/test_sflash_cmd_engine.sv
`timescale 1ns/1ps
module test_sflash_cmd_engine;
  localparam int ADDR_W = 11;
  localparam int HALF   = 1;
  localparam int PER    = 2 * HALF;
  localparam int TXB    = 8;
  localparam int RXB    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  sflash_cmd_engine #(.ADDR_W(ADDR_W), .SCK_HALF(HALF), .TX_BYTES(TXB), .RX_BYTES(RXB))
    i_sflash_cmd_engine (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of the host-visible register contents
  int m_n = 0;
  logic [7:0] m_cmd = 0;
  logic [7:0] m_adr [3] = '{default: 8'h00};
  logic [7:0] m_tx [TXB] = '{default: 8'h00};
  logic [2:0] exp_q [$];   // {cs_n, sck, mosi} per cycle
  int rises = 0;
  int rcnt = 0;
  int seed = 0;
  bit mon_en = 0;
  logic prev_sck = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(int j);
    return 8'(j * 29 + seed);
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic sbit(int k);
    int bi = k / 8;
    logic [7:0] b;
    if (bi == 0) b = m_cmd;
    else if (bi < 4) b = m_adr[bi-1];
    else if (bi - 4 < TXB) b = m_tx[bi-4];
    else b = 8'h00;
    return b[k % 8];
  endfunction

  task automatic push_transfer();
    for (int c = 0; c < PER; c++) exp_q.push_back({2'b00, sbit(0)});
    for (int k = 0; k < m_n; k++) begin
      for (int h = 0; h < HALF; h++) exp_q.push_back({2'b01, sbit(k)});
      if (k < m_n - 1)
        for (int h = 0; h < HALF; h++) exp_q.push_back({2'b00, sbit(k + 1)});
    end
    for (int c = 0; c < PER; c++) exp_q.push_back(3'b000);
  endtask

  // per-cycle comparison against the reference stream, plus flash input model
  always @(negedge clk) begin
    if (mon_en && !done) begin
      logic [2:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 3'b100;
      chk("R2 cs_n", int'(spi_cs_n), int'(e[2]));
      chk("R2 sck", int'(spi_sck), int'(e[1]));
      chk("R3 mosi", int'(spi_mosi), int'(e[0]));
      if (spi_sck && !prev_sck) begin rises++; rcnt++; end
      prev_sck = spi_sck;
      if (spi_cs_n) begin rcnt = 0; spi_miso = 1'b0; end
      else begin
        logic [7:0] rb;
        rb = rbyte(rcnt / 8);
        spi_miso = rb[rcnt % 8];
      end
    end
  end

  task automatic wr(int addr, int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = 8'(data);
    @(posedge clk); #1;
    if (exp_q.size() == 0) begin
      if (addr == 'h7F8 && data == 'hFF) begin rises = 0; push_transfer(); end
      else if (addr == 'h00) m_n = (m_n & 'hFF) | (data << 8);
      else if (addr == 'h08) m_n = (m_n & 'hFF00) | data;
      else if (addr == 'h10) m_cmd = 8'(data);
      else if (addr == 'h18) m_adr[0] = 8'(data);
      else if (addr == 'h20) m_adr[1] = 8'(data);
      else if (addr == 'h28) m_adr[2] = 8'(data);
      else if (addr >= 'h30 && addr % 8 == 0 && (addr - 'h30) / 8 < TXB) m_tx[(addr - 'h30) / 8] = 8'(data);
    end
    bus_wr = 1'b0;
  endtask

  task automatic rd(int addr, output int data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr);
    @(negedge clk);
    data = int'(bus_rdata);
  endtask

  task automatic setup(int n, int c, int a);
    wr('h00, n >> 8); wr('h08, n & 'hFF); wr('h10, c);
    wr('h18, rev8(8'(a >> 16))); wr('h20, rev8(8'(a >> 8))); wr('h28, rev8(8'(a)));
  endtask

  task automatic wait_done();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R4 rising edge count", rises, m_n);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sck", int'(spi_sck), 0);
    chk("R1 mosi", int'(spi_mosi), 0);
    rd('h01, v); chk("R1 busy idle", v, 0);
    mon_en = 1;

    // write enable, 8 clocks
    setup(8, 'h60, 0); wr('h7F8, 'hFF);
    rd('h01, v); chk("R5 busy during transfer", v, 1);
    wait_done();
    rd('h01, v); chk("R5 busy after transfer", v, 0);

    // status read, 16 clocks
    seed = 'h33; setup(16, 'hA0, 0); wr('h7F8, 'hFF); wait_done();
    rd('h20, v); chk("R6 status byte", v, int'(rbyte(1)));

    // identifier read, 40 clocks
    seed = 'h70; setup(40, 'hD5, 0); wr('h7F8, 'hFF); wait_done();
    rd('h38, v); chk("R6 R7 identifier byte", v, int'(rbyte(4)));

    // array read over the full window plus a partial byte
    seed = 'h15; setup(32 + 8 * RXB + 5, 'hC0, 'h01A2C3); wr('h7F8, 'hFF); wait_done();
    for (int i = 0; i < RXB; i++) begin
      rd('h38 + 8 * i, v); chk("R7 capture window", v, int'(rbyte(4 + i)));
    end
    rd('h38 + 8 * RXB, v); chk("R7 beyond window", v, 0);
    rd('h20, v); chk("R6 byte1 after array read", v, int'(rbyte(1)));

    // page write of 260 clocks: data bytes then zeros past TX end (R10)
    for (int i = 0; i < TXB; i++) wr('h30 + 8 * i, 'h81 + 17 * i);
    setup(260, 'h40, 'h000100); wr('h7F8, 'hFF);
    repeat (20) @(negedge clk);
    rd('h01, v); chk("R5 busy mid write", v, 1);
    wr('h7F8, 'hFF);          // R8 restart ignored
    wr('h10, 'h11);           // R9 dropped
    wr('h08, 'h02);           // R9 dropped
    wr('h30, 'h99);           // R9 dropped
    wait_done();              // stream compare covers R3 R8 R9 R10

    // R9: rerun without rewriting, old values must reappear
    wr('h7F8, 'hFF); wait_done();

    // R8: wrong key starts nothing
    wr('h7F8, 'h7F);
    repeat (10) @(negedge clk);
    chk("R8 wrong key no clocks", rises, m_n);
    rd('h01, v); chk("R8 wrong key not busy", v, 0);

    // R4: zero clocks, framing only
    setup(0, 'hE3, 0); wr('h7F8, 'hFF); wait_done();

    // odd count, partial last byte
    seed = 'h5C; setup(13, 'hD5, 0); wr('h7F8, 'hFF); wait_done();
    rd('h20, v); chk("R7 partial byte not stored", v, int'(8'h5C + 8'd29 == 8'h79 ? 8'h00 : 8'h00) | int'(8'(29*1 + 'h15)));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule